// File: doc/BRIEF.md
# Capture Adapter Self-Test Sequencer

This block is a built-in test engine for a parallel-port capture adapter. It drives the adapter through the host-side lines only: a loopback line, a line that holds the busy latch clear, a forced strobe, an acknowledge request, and a shift clock with a serial data line. It watches the adapter's answers: the loopback return, the data-ready line, the sensed strobe line, the acknowledge echo, and the serial output with its complement. Each run reports a 4-bit result code. When a data comparison fails, it also reports a 16-bit word that holds the byte sent and the byte received.

A one-cycle pulse on `start_i` launches a run. One pass has three steps. The presence step toggles the loopback line and records the idle sense of the ready line. The logic step forces a strobe and then requests an acknowledge pulse, judging its length. The loop-through step shifts four known bytes through the adapter's serial register and reads them back. The pass repeats for the requested number of iterations. The first failure ends the run at once with its own code and puts every adapter line back at its idle level. `done_o` then rises together with the result and stays high until the next start.

States and transitions:
- `S_IDLE` goes to `S_LOOP_LO` on start.
- `S_LOOP_LO` goes to `S_LOOP_LO_CHK`, then to `S_LOOP_HI`, then to `S_LOOP_HI_CHK`, then to `S_CLEAR`, then to `S_SENSE`.
- `S_SENSE` goes to `S_STROBE`.
- `S_STROBE` waits for ready, then goes to `S_UNSTROBE`, then to `S_ACK`.
- `S_ACK` goes to `S_ACK_WAIT`, which waits for the echo to begin. It then goes to `S_ACK_HIGH`, which waits for the echo to end, and then to `S_BUSY_CHK`.
- `S_BUSY_CHK` goes to `S_WR`. The write phase alternates `S_WR` and `S_WR_CLK` eight times. The read phase then alternates `S_RD` and `S_RD_CLK` eight times, followed by `S_CMP`.
- `S_CMP` goes to `S_WR` for the next byte, to `S_LOOP_LO` for the next iteration, or to `S_DONE` after the last one.
- Every failing check goes straight to `S_DONE`.
- `S_DONE` goes back to `S_LOOP_LO` on a new start.

Top module: `selftest_seq`

## Requirements
- R1: A start pulse drives `loop_out_o` low for two cycles and then high for two cycles. If `loop_in_i` does not follow both levels, the run ends with code 2.
- R2: While the busy latch is held clear (`latch_clr_n_o` low), the level of `ready_i` is recorded as its idle sense. From then on, ready counts as asserted when `ready_i` differs from that sense, so both polarities of the ready line pass.
- R3: While the latch is held clear, the sensed strobe line `strobe_seen_i` must be low; otherwise the run ends with code 9. Code 9 takes priority over code 5 when both faults are present in the same cycle.
- R4: If `ack_echo_i` is high while the latch is held clear, before any acknowledge request has been made, the run ends with code 5.
- R5: After `strobe_force_o` rises, ready must assert within TIMEOUT cycles; otherwise the run ends with code 4.
- R6: After a one-cycle low pulse on `ack_req_n_o`, `ack_echo_i` must go high within TIMEOUT cycles; otherwise the run ends with code 6.
- R7: An echo pulse may last at most ACK_MAX cycles. A pulse of exactly ACK_MAX cycles passes, and one of ACK_MAX+1 cycles ends the run with code 7.
- R8: If ready is still asserted in the first cycle after the echo ends, the run ends with code 8.
- R9: The loop-through step shifts the bytes 0x00, 0xFF, 0x55 and 0xAA, in that order. Each byte goes out bit 0 first on `ser_out_o`, one bit per falling edge of `shift_clk_n_o`. Eight read clocks follow each byte, with `ser_out_o` held at 1.
- R10: Before each read clock, `ser_in_i` and `ser_in_n_i` must be opposite; otherwise the run ends with code 10.
- R11: If the byte read back differs from the byte sent, the run ends with code 11. In that case `fail_word_o` holds the sent byte in bits 7:0 and the received byte in bits 15:8. For any other result, `fail_word_o` is 0.
- R12: The whole pass repeats `iter_count_i` times, and a count of 0 runs once. After the last iteration succeeds, the result is code 0.
- R13: When `done_o` is high, every adapter line is at its idle level: `loop_out_o`=1, `latch_clr_n_o`=1, `strobe_force_o`=0, `ack_req_n_o`=1, `shift_clk_n_o`=1 and `ser_out_o`=1. The result then holds until the next start. After reset, `done_o` is 0 and `result_o` is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | One-cycle pulse that launches a run |
| iter_count_i | input | ITER_W | Number of passes (0 means one pass) |
| loop_out_o | output | 1 | Loopback drive to the adapter |
| loop_in_i | input | 1 | Loopback return from the adapter |
| latch_clr_n_o | output | 1 | Low holds the adapter busy latch clear |
| ready_i | input | 1 | Data-ready line, polarity set by the adapter |
| strobe_force_o | output | 1 | High forces a strobe on the adapter |
| strobe_seen_i | input | 1 | High when the strobe line is sensed active |
| ack_req_n_o | output | 1 | Low pulse requests an acknowledge |
| ack_echo_i | input | 1 | High while the acknowledge pulse is active |
| shift_clk_n_o | output | 1 | Shift clock, active on its falling edge |
| ser_out_o | output | 1 | Serial data into the adapter shift register |
| ser_in_i | input | 1 | Serial data from the adapter |
| ser_in_n_i | input | 1 | Complement of the serial data from the adapter |
| done_o | output | 1 | High when the result is valid |
| result_o | output | 4 | Result code |
| fail_word_o | output | 16 | Received byte in bits 15:8, sent byte in bits 7:0, on code 11 |

## Verification
In the sense state, the strobe-stuck check and the echo-stuck check judge the same cycle. The bench raises both faults together and expects code 9 rather than code 5. In the echo-length check, the cycle in which the echo falls can coincide with the cycle in which the length limit is reached. The bench provokes this with an adapter model whose echo lasts exactly ACK_MAX cycles, which must pass, and then ACK_MAX+1 cycles, which must give code 7.

// File: rtl/selftest_pkg.sv
package selftest_pkg;

    typedef enum logic [4:0] {
        S_IDLE, S_LOOP_LO, S_LOOP_LO_CHK, S_LOOP_HI, S_LOOP_HI_CHK,
        S_CLEAR, S_SENSE, S_STROBE, S_UNSTROBE, S_ACK, S_ACK_WAIT,
        S_ACK_HIGH, S_BUSY_CHK, S_WR, S_WR_CLK, S_RD, S_RD_CLK,
        S_CMP, S_DONE
    } state_t;

    localparam logic [3:0] RC_PASS         = 4'd0;
    localparam logic [3:0] RC_ABSENT       = 4'd2;
    localparam logic [3:0] RC_NO_READY     = 4'd4;
    localparam logic [3:0] RC_ECHO_STUCK   = 4'd5;
    localparam logic [3:0] RC_NO_ECHO      = 4'd6;
    localparam logic [3:0] RC_ECHO_LONG    = 4'd7;
    localparam logic [3:0] RC_BUSY_STUCK   = 4'd8;
    localparam logic [3:0] RC_STROBE_STUCK = 4'd9;
    localparam logic [3:0] RC_COMPL        = 4'd10;
    localparam logic [3:0] RC_MISMATCH     = 4'd11;

    // Loop-through byte order
    function automatic logic [7:0] pattern_of(input logic [1:0] k);
        case (k)
            2'd0:    return 8'h00;
            2'd1:    return 8'hFF;
            2'd2:    return 8'h55;
            default: return 8'hAA;
        endcase
    endfunction

endpackage

// File: rtl/selftest_ctr.sv
module selftest_ctr #(
    parameter int W = 4
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         clr,
    input  logic         inc,
    output logic [W-1:0] value
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)   value <= '0;
        else if (clr) value <= '0;
        else if (inc) value <= value + 1'b1;
    end
endmodule

// File: rtl/selftest_seq.sv
module selftest_seq
    import selftest_pkg::*;
#(
    parameter int TIMEOUT = 64,
    parameter int ACK_MAX = 32,
    parameter int ITER_W  = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_i,
    input  logic [ITER_W-1:0] iter_count_i,
    output logic              loop_out_o,
    input  logic              loop_in_i,
    output logic              latch_clr_n_o,
    input  logic              ready_i,
    output logic              strobe_force_o,
    input  logic              strobe_seen_i,
    output logic              ack_req_n_o,
    input  logic              ack_echo_i,
    output logic              shift_clk_n_o,
    output logic              ser_out_o,
    input  logic              ser_in_i,
    input  logic              ser_in_n_i,
    output logic              done_o,
    output logic [3:0]        result_o,
    output logic [15:0]       fail_word_o
);
    localparam int LIM   = (TIMEOUT > ACK_MAX) ? TIMEOUT : ACK_MAX;
    localparam int CNT_W = $clog2(LIM + 1);
    localparam logic [CNT_W-1:0] T_LAST = CNT_W'(TIMEOUT - 1);
    localparam logic [CNT_W-1:0] A_LAST = CNT_W'(ACK_MAX - 1);

    state_t state, nxt;
    logic [CNT_W-1:0]  tmr_val;
    logic [2:0]        bit_val;
    logic [1:0]        pat_val;
    logic [ITER_W-1:0] it_val, it_target;
    logic tmr_clr, tmr_inc, bit_clr, bit_inc, pat_clr, pat_inc, it_clr, it_inc;
    logic fail, finish_ok, pol;
    logic [3:0] code;
    logic [7:0] rx, cur_pat;
    logic ready_n;

    assign cur_pat = pattern_of(pat_val);
    assign ready_n = ready_i ^ pol;

    selftest_ctr #(.W(CNT_W))  u_tmr (.clk(clk), .rst_n(rst_n), .clr(tmr_clr), .inc(tmr_inc), .value(tmr_val));
    selftest_ctr #(.W(3))      u_bit (.clk(clk), .rst_n(rst_n), .clr(bit_clr), .inc(bit_inc), .value(bit_val));
    selftest_ctr #(.W(2))      u_pat (.clk(clk), .rst_n(rst_n), .clr(pat_clr), .inc(pat_inc), .value(pat_val));
    selftest_ctr #(.W(ITER_W)) u_it  (.clk(clk), .rst_n(rst_n), .clr(it_clr),  .inc(it_inc),  .value(it_val));

    // Next state and counter control
    always_comb begin
        nxt = state;
        fail = 1'b0; finish_ok = 1'b0; code = RC_PASS;
        tmr_clr = 1'b0; tmr_inc = 1'b0; bit_clr = 1'b0; bit_inc = 1'b0;
        pat_clr = 1'b0; pat_inc = 1'b0; it_clr = 1'b0; it_inc = 1'b0;
        unique case (state)
            S_IDLE, S_DONE: if (start_i) begin
                nxt = S_LOOP_LO; it_clr = 1'b1; pat_clr = 1'b1; bit_clr = 1'b1;
            end
            S_LOOP_LO:     nxt = S_LOOP_LO_CHK;
            S_LOOP_LO_CHK: if (loop_in_i) begin fail = 1'b1; code = RC_ABSENT; end
                           else nxt = S_LOOP_HI;
            S_LOOP_HI:     nxt = S_LOOP_HI_CHK;
            S_LOOP_HI_CHK: if (!loop_in_i) begin fail = 1'b1; code = RC_ABSENT; end
                           else nxt = S_CLEAR;
            S_CLEAR:       nxt = S_SENSE;
            S_SENSE: begin
                if (strobe_seen_i)   begin fail = 1'b1; code = RC_STROBE_STUCK; end
                else if (ack_echo_i) begin fail = 1'b1; code = RC_ECHO_STUCK; end
                else begin nxt = S_STROBE; tmr_clr = 1'b1; end
            end
            S_STROBE: begin
                if (ready_n) nxt = S_UNSTROBE;
                else if (tmr_val == T_LAST) begin fail = 1'b1; code = RC_NO_READY; end
                else tmr_inc = 1'b1;
            end
            S_UNSTROBE: nxt = S_ACK;
            S_ACK: begin nxt = S_ACK_WAIT; tmr_clr = 1'b1; end
            S_ACK_WAIT: begin
                if (ack_echo_i) begin nxt = S_ACK_HIGH; tmr_clr = 1'b1; end
                else if (tmr_val == T_LAST) begin fail = 1'b1; code = RC_NO_ECHO; end
                else tmr_inc = 1'b1;
            end
            S_ACK_HIGH: begin
                if (!ack_echo_i) nxt = S_BUSY_CHK;
                else if (tmr_val == A_LAST) begin fail = 1'b1; code = RC_ECHO_LONG; end
                else tmr_inc = 1'b1;
            end
            S_BUSY_CHK: begin
                if (ready_n) begin fail = 1'b1; code = RC_BUSY_STUCK; end
                else begin nxt = S_WR; bit_clr = 1'b1; pat_clr = 1'b1; end
            end
            S_WR:     nxt = S_WR_CLK;
            S_WR_CLK: begin bit_inc = 1'b1; nxt = (bit_val == 3'd7) ? S_RD : S_WR; end
            S_RD: begin
                if (ser_in_i == ser_in_n_i) begin fail = 1'b1; code = RC_COMPL; end
                else nxt = S_RD_CLK;
            end
            S_RD_CLK: begin bit_inc = 1'b1; nxt = (bit_val == 3'd7) ? S_CMP : S_RD; end
            S_CMP: begin
                if (rx != cur_pat) begin fail = 1'b1; code = RC_MISMATCH; end
                else if (pat_val == 2'd3) begin
                    pat_inc = 1'b1;
                    if (it_val == ITER_W'(it_target - 1'b1)) finish_ok = 1'b1;
                    else begin it_inc = 1'b1; nxt = S_LOOP_LO; end
                end else begin pat_inc = 1'b1; nxt = S_WR; end
            end
            default: nxt = S_IDLE;
        endcase
        if (fail || finish_ok) nxt = S_DONE;
    end

    // State register and result capture
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= S_IDLE; result_o <= RC_PASS; fail_word_o <= '0;
            pol <= 1'b0; rx <= '0; it_target <= '0;
        end else begin
            state <= nxt;
            if ((state == S_IDLE || state == S_DONE) && start_i) begin
                result_o    <= RC_PASS;
                fail_word_o <= '0;
                it_target   <= (iter_count_i == '0) ? ITER_W'(1) : iter_count_i;
            end
            if (state == S_SENSE) pol <= ready_i;
            if (state == S_RD) rx[bit_val] <= ser_in_i;
            if (fail) begin
                result_o <= code;
                if (code == RC_MISMATCH) fail_word_o <= {rx, cur_pat};
            end
        end
    end

    // Adapter lines from state
    always_comb begin
        loop_out_o     = !(state == S_LOOP_LO || state == S_LOOP_LO_CHK);
        latch_clr_n_o  = !(state == S_CLEAR || state == S_SENSE);
        strobe_force_o = (state == S_STROBE);
        ack_req_n_o    = (state != S_ACK);
        shift_clk_n_o  = !(state == S_WR_CLK || state == S_RD_CLK);
        ser_out_o      = (state == S_WR || state == S_WR_CLK) ? cur_pat[bit_val] : 1'b1;
        done_o         = (state == S_DONE);
    end
endmodule

// File: rtl/selftest_seq_chk.sv
module selftest_seq_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        start_i,
    input logic        loop_out_o,
    input logic        latch_clr_n_o,
    input logic        strobe_force_o,
    input logic        ack_req_n_o,
    input logic        shift_clk_n_o,
    input logic        ser_out_o,
    input logic        done_o,
    input logic [3:0]  result_o,
    input logic [15:0] fail_word_o
);
    // R13
    idle_lines_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> (loop_out_o && latch_clr_n_o && !strobe_force_o &&
                    ack_req_n_o && shift_clk_n_o && ser_out_o));
    // R13
    result_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (done_o && !start_i) |=> (done_o && $stable(result_o)));
    // R11
    fail_word_clean_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (done_o && result_o != 4'd11) |-> (fail_word_o == 16'd0));
    // R6
    ack_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !ack_req_n_o |=> ack_req_n_o);
    // R9
    shift_strobe_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(strobe_force_o && !shift_clk_n_o));
    // R13
    legal_code_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> (result_o inside {4'd0, 4'd2, [4'd4:4'd11]}));
endmodule

bind selftest_seq selftest_seq_chk u_chk (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .loop_out_o(loop_out_o),
    .latch_clr_n_o(latch_clr_n_o), .strobe_force_o(strobe_force_o),
    .ack_req_n_o(ack_req_n_o), .shift_clk_n_o(shift_clk_n_o),
    .ser_out_o(ser_out_o), .done_o(done_o), .result_o(result_o),
    .fail_word_o(fail_word_o)
);

// File: tb/selftest_seq_bench.sv
`timescale 1ns/1ps
module selftest_seq_bench;
    localparam int TO = 20, AM = 8, IW = 4;

    logic clk = 1'b0, rst_n = 1'b0, start = 1'b0;
    logic [IW-1:0] iters = '0;
    logic loop_out, loop_in, latch_clr_n, ready, strobe_force, strobe_seen;
    logic ack_req_n, ack_echo, shift_clk_n, ser_out, ser_in, ser_in_n, done;
    logic [3:0] result;
    logic [15:0] fail_word;

    int checks = 0, errors = 0, cycles = 0;

    // adapter model knobs
    logic f_loop_broken = 0, f_pol_neg = 0, f_strobe_stuck = 0, f_echo_stuck = 0;
    logic f_echo_never = 0, f_ready_never = 0, f_ready_stuck = 0;
    logic f_compl_bad = 0, f_sdi_zero = 0;
    int echo_len = 3;

    logic ready_q = 0, ack_prev = 1, clk_prev = 1, lo_prev = 1;
    int echo_cnt = 0, shift_n = 0, loop_pulses = 0;
    logic [7:0] sr = 8'h00;
    logic shift_log [0:63];

    always #2.5 clk = ~clk;

    selftest_seq #(.TIMEOUT(TO), .ACK_MAX(AM), .ITER_W(IW)) u_selftest_seq (
        .clk(clk), .rst_n(rst_n), .start_i(start), .iter_count_i(iters),
        .loop_out_o(loop_out), .loop_in_i(loop_in), .latch_clr_n_o(latch_clr_n),
        .ready_i(ready), .strobe_force_o(strobe_force), .strobe_seen_i(strobe_seen),
        .ack_req_n_o(ack_req_n), .ack_echo_i(ack_echo), .shift_clk_n_o(shift_clk_n),
        .ser_out_o(ser_out), .ser_in_i(ser_in), .ser_in_n_i(ser_in_n),
        .done_o(done), .result_o(result), .fail_word_o(fail_word));

    assign loop_in     = f_loop_broken ? 1'b0 : loop_out;
    assign strobe_seen = strobe_force | f_strobe_stuck;
    assign ready       = ready_q ^ f_pol_neg;
    assign ack_echo    = (echo_cnt != 0) | f_echo_stuck;
    assign ser_in      = f_sdi_zero ? 1'b0 : sr[0];
    assign ser_in_n    = f_compl_bad ? ser_in : ~ser_in;

    always @(posedge clk) begin
        cycles <= cycles + 1;
        ack_prev <= ack_req_n;
        clk_prev <= shift_clk_n;
        lo_prev  <= loop_out;
        if (lo_prev && !loop_out) loop_pulses <= loop_pulses + 1;
        if (!latch_clr_n) ready_q <= 1'b0;
        else if (strobe_seen && !f_ready_never) ready_q <= 1'b1;
        else if (ack_prev && !ack_req_n && !f_ready_stuck) ready_q <= 1'b0;
        if (ack_prev && !ack_req_n && !f_echo_never) echo_cnt <= echo_len;
        else if (echo_cnt != 0) echo_cnt <= echo_cnt - 1;
        if (clk_prev && !shift_clk_n) begin
            sr <= {ser_out, sr[7:1]};
            if (shift_n < 64) shift_log[shift_n] <= ser_out;
            shift_n <= shift_n + 1;
        end
    end

    task automatic finish_now();
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    endtask

    always @(posedge clk) if (cycles > 150000) begin
        errors = errors + 1;
        $display("FAIL watchdog: actual %0d cycles expected fewer", cycles);
        finish_now();
    end

    task automatic chk(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual %0d (0x%0h) expected %0d (0x%0h)", tag, act, act, exp, exp);
        end
    endtask

    task automatic clear_faults();
        f_loop_broken = 0; f_pol_neg = 0; f_strobe_stuck = 0; f_echo_stuck = 0;
        f_echo_never = 0; f_ready_never = 0; f_ready_stuck = 0;
        f_compl_bad = 0; f_sdi_zero = 0; echo_len = 3;
    endtask

    task automatic run(input logic [IW-1:0] n);
        @(negedge clk);
        iters = n; shift_n = 0; loop_pulses = 0; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        for (int i = 0; i < 4000 && !done; i++) @(negedge clk);
    endtask

    task automatic expect_code(input string tag, input int code);
        chk({tag, " done"}, done, 1);
        chk({tag, " code"}, result, code);
        chk({tag, " R13 idle lines"},
            {loop_out, latch_clr_n, strobe_force, ack_req_n, shift_clk_n, ser_out}, 6'b110111);
    endtask

    task automatic t_reset();
        chk("R13 reset done", done, 0);
        chk("R13 reset result", result, 0);
        chk("R13 reset lines", {loop_out, latch_clr_n, strobe_force, ack_req_n, shift_clk_n}, 5'b11011);
    endtask

    task automatic t_pass_patterns();
        clear_faults(); run(1);
        expect_code("R12 single pass", 0);
        chk("R11 pass fail word", fail_word, 0);
        for (int k = 0; k < 4; k++) begin
            logic [7:0] p;
            logic [7:0] got, tail;
            p = (k == 0) ? 8'h00 : (k == 1) ? 8'hFF : (k == 2) ? 8'h55 : 8'hAA;
            for (int i = 0; i < 8; i++) begin
                got[i]  = shift_log[k*16 + i];
                tail[i] = shift_log[k*16 + 8 + i];
            end
            chk("R9 byte sent", got, p);
            chk("R9 read fill", tail, 8'hFF);
        end
        repeat (3) @(negedge clk);
        chk("R13 result held", {done, result}, {1'b1, 4'd0});
    endtask

    task automatic t_iterations();
        clear_faults(); run(3);
        expect_code("R12 three passes", 0);
        chk("R12 presence count 3", loop_pulses, 3);
        chk("R1 presence count", loop_pulses, 3);
        run(0);
        chk("R12 zero means one", loop_pulses, 1);
    endtask

    task automatic t_absent();
        clear_faults(); f_loop_broken = 1; run(1);
        expect_code("R1 absent", 2);
    endtask

    task automatic t_polarity();
        clear_faults(); f_pol_neg = 1; run(2);
        expect_code("R2 negative ready sense", 0);
    endtask

    task automatic t_strobe_echo();
        clear_faults(); f_strobe_stuck = 1; run(1);
        expect_code("R3 strobe stuck", 9);
        clear_faults(); f_echo_stuck = 1; run(1);
        expect_code("R4 echo stuck", 5);
        clear_faults(); f_echo_stuck = 1; f_strobe_stuck = 1; run(1);
        expect_code("R3 priority over echo stuck", 9);
    endtask

    task automatic t_ready_ack();
        clear_faults(); f_ready_never = 1; run(1);
        expect_code("R5 no ready", 4);
        clear_faults(); f_echo_never = 1; run(1);
        expect_code("R6 no echo", 6);
        clear_faults(); echo_len = AM; run(1);
        expect_code("R7 echo at limit", 0);
        clear_faults(); echo_len = AM + 1; run(1);
        expect_code("R7 echo too long", 7);
        clear_faults(); f_ready_stuck = 1; run(1);
        expect_code("R8 busy stuck", 8);
    endtask

    task automatic t_serial();
        clear_faults(); f_compl_bad = 1; run(1);
        expect_code("R10 complement", 10);
        clear_faults(); f_sdi_zero = 1; run(1);
        expect_code("R11 mismatch", 11);
        chk("R11 fail word", fail_word, 16'h00FF);
        clear_faults(); run(1);
        expect_code("R13 recovery", 0);
        chk("R11 word cleared", fail_word, 0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        @(negedge clk);
        t_pass_patterns();
        t_iterations();
        t_absent();
        t_polarity();
        t_strobe_echo();
        t_ready_ack();
        t_serial();
        finish_now();
    end
endmodule